// File: doc/BRIEF.md
# Next-PC Branch and Jump Target Unit

This block works out which instruction address a 32-bit load-store processor fetches next. It is purely combinational. It takes the address of the current instruction, the instruction word and the two register operand values read for it. From these it produces the next fetch address. When a call instruction is decoded, it also produces a write request for the return-address register.

Conditional branches compare the two operands for equality or inequality. A taken branch moves by a signed word offset relative to the following instruction. Direct jumps and calls replace the low 28 bits of the address with a word index from the instruction. An indirect jump takes the address from the first operand. Every other instruction falls through to the next sequential word.

The instruction layout is as follows. The opcode is in bits [31:26]. The branch offset is in bits [15:0]. The jump index is in bits [25:0]. The function code is in bits [5:0].

Top module: `branch_target_unit`

## Requirements
- R1: For any opcode other than 2, 3, 4 and 5, and other than opcode 0 with function code 8, `next_pc_o` equals `pc_i + 4` modulo 2^32 and `link_we_o` is 0.
- R2: For opcode 4, when `rs_val_i == rt_val_i`, `next_pc_o` equals `pc_i + 4 + (sign-extended bits [15:0] × 4)`. Otherwise it equals `pc_i + 4`.
- R3: For opcode 5, the same target is taken when `rs_val_i != rt_val_i`. Otherwise `next_pc_o` is `pc_i + 4`.
- R4: For opcode 2, `next_pc_o` is `{(pc_i+4)[31:28], instr_i[25:0], 2'b00}`. The field therefore counts words, so a field of 2500 in the region of zero gives 10000.
- R5: Opcode 3 forms the same target as R4. It also drives `link_we_o` to 1, `link_idx_o` to 31 and `link_val_o` to `pc_i + 4`.
- R6: Opcode 0 with function code 8 in bits [5:0] gives `next_pc_o = rs_val_i`.
- R7: `link_we_o` is 1 only for opcode 3. For every other instruction, `link_we_o`, `link_idx_o` and `link_val_o` are all 0.
- R8: All target sums wrap modulo 2^32. A negative offset can move the address backwards past zero, and a positive one can move it forwards past the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Fetched instruction word |
| rs_val_i | input | 32 | First register operand value |
| rt_val_i | input | 32 | Second register operand value |
| next_pc_o | output | 32 | Next fetch address |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address register index |
| link_val_o | output | 32 | Return address to write |

## Verification
Three conditions are hard to reach from the ports: offsets that carry the branch sum across the 2^32 boundary, jumps whose `pc_i + 4` crosses into a new 256 MB region, and opcode 0 with a function code close to 8. The bench gets there by sweeping all 64 opcodes and all 64 function codes against a set of edge addresses, including 0x0FFFFFFC and 0xFFFFFFFC. It also walks the extreme offsets 0x7FFF, 0x8000 and 0xFFFF. Operand pairs that are equal, unequal and differ in a single bit drive both outcomes of each branch.

// File: rtl/branch_target_unit.sv
module branch_target_unit #(
  parameter int unsigned LINK_REG = 31
) (
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] next_pc_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_val_o
);

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_CALL    = 6'd3;
  localparam logic [5:0] OP_BR_EQ   = 6'd4;
  localparam logic [5:0] OP_BR_NE   = 6'd5;
  localparam logic [5:0] FN_JREG    = 6'd8;
  localparam logic [4:0] LINK_IDX   = 5'(LINK_REG);

  logic [5:0]  opcode;
  logic [5:0]  funct;
  logic [31:0] seq_pc;
  logic [31:0] rel_pc;
  logic [31:0] abs_pc;
  logic        same;

  assign opcode = instr_i[31:26];
  assign funct  = instr_i[5:0];
  assign seq_pc = pc_i + 32'd4;
  assign rel_pc = seq_pc + {{14{instr_i[15]}}, instr_i[15:0], 2'b00};
  assign abs_pc = {seq_pc[31:28], instr_i[25:0], 2'b00};
  assign same   = (rs_val_i == rt_val_i);

  always_comb begin
    next_pc_o  = seq_pc;
    link_we_o  = 1'b0;
    link_idx_o = '0;
    link_val_o = '0;
    case (opcode)
      OP_BR_EQ:   if (same)  next_pc_o = rel_pc;
      OP_BR_NE:   if (!same) next_pc_o = rel_pc;
      OP_JUMP:    next_pc_o = abs_pc;
      OP_CALL: begin
        next_pc_o  = abs_pc;
        link_we_o  = 1'b1;
        link_idx_o = LINK_IDX;
        link_val_o = seq_pc;
      end
      OP_SPECIAL: if (funct == FN_JREG) next_pc_o = rs_val_i;
      default:    next_pc_o = seq_pc;
    endcase
  end

  always_comb begin
    if (!$isunknown({pc_i, instr_i, rs_val_i, rt_val_i})) begin
      AST_LINK_ONLY_CALL: assert (!link_we_o || opcode == OP_CALL) else $error("link write outside call"); // R7
      AST_LINK_PAYLOAD: assert (!link_we_o || (link_idx_o == 5'd31 && link_val_o - pc_i == 32'd4)) else $error("bad link payload"); // R5
      AST_JUMP_REGION: assert (!(opcode == OP_JUMP || opcode == OP_CALL) || (next_pc_o[31:28] == seq_pc[31:28] && next_pc_o[1:0] == 2'b00)) else $error("jump left region"); // R4
      AST_BRANCH_ALIGN: assert (!(opcode == OP_BR_EQ || opcode == OP_BR_NE) || next_pc_o[1:0] == pc_i[1:0]) else $error("branch misaligned"); // R2
      AST_NE_FALLTHRU: assert (!(opcode == OP_BR_NE && same) || next_pc_o - pc_i == 32'd4) else $error("bne taken on equal"); // R3
      AST_JREG_TARGET: assert (!(opcode == OP_SPECIAL && funct == FN_JREG) || next_pc_o == rs_val_i) else $error("jr target"); // R6
    end
  end

endmodule

// File: tb/branch_target_unit_tb.sv
module branch_target_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] pc, instr, ra, rb;
  logic [31:0] next_pc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;
  int          vectors = 0;
  int          misses  = 0;
  logic [31:0] seed    = 32'h1234_5678;

  branch_target_unit dut_i (
    .pc_i(pc), .instr_i(instr), .rs_val_i(ra), .rt_val_i(rb),
    .next_pc_o(next_pc), .link_we_o(link_we), .link_idx_o(link_idx), .link_val_o(link_val)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic apply(input logic [31:0] p, input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] e_pc, e_lv, seq;
    logic        e_we;
    logic [4:0]  e_ix;
    longint      off;
    string       tag;
    @(negedge clk);
    pc = p; instr = ins; ra = a; rb = b;
    seq  = p + 32'd4;
    off  = longint'($signed(ins[15:0])) * 4;
    e_pc = seq; e_we = 1'b0; e_ix = 5'd0; e_lv = 32'd0; tag = "R1";
    if (ins[31:26] == 6'd4) begin
      tag = "R2/R8";
      if (a == b) e_pc = 32'(longint'(seq) + off);
    end else if (ins[31:26] == 6'd5) begin
      tag = "R3/R8";
      if (a != b) e_pc = 32'(longint'(seq) + off);
    end else if (ins[31:26] == 6'd2) begin
      tag = "R4";
      e_pc = (seq & 32'hF000_0000) + ins[25:0] * 4;
    end else if (ins[31:26] == 6'd3) begin
      tag = "R5";
      e_pc = (seq & 32'hF000_0000) + ins[25:0] * 4;
      e_we = 1'b1; e_ix = 5'd31; e_lv = seq;
    end else if (ins[31:26] == 6'd0 && ins[5:0] == 6'd8) begin
      tag = "R6";
      e_pc = a;
    end
    @(posedge clk);
    #1;
    vectors++;
    if (next_pc !== e_pc || link_we !== e_we || link_idx !== e_ix || link_val !== e_lv) begin
      misses++;
      $display("FAIL %s (R7 link) op=%0d pc=%h: got next=%h we=%b idx=%0d val=%h, exp next=%h we=%b idx=%0d val=%h",
               tag, ins[31:26], p, next_pc, link_we, link_idx, link_val, e_pc, e_we, e_ix, e_lv);
    end
  endtask

  initial begin
    logic [31:0] pcs [5];
    logic [15:0] offs [6];
    pcs[0] = 32'h0000_0000; pcs[1] = 32'h0040_0010; pcs[2] = 32'h0FFF_FFFC;
    pcs[3] = 32'hFFFF_FFFC; pcs[4] = 32'h7FFE_FFF0;
    offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'h7FFF;
    offs[3] = 16'h8000; offs[4] = 16'hFFFF; offs[5] = 16'hFFF0;
    pc = '0; instr = '0; ra = '0; rb = '0;
    // R1 R2 R3 R4 R5 R6 R7: every opcode against edge addresses and operand pairs
    for (int op = 0; op < 64; op++)
      for (int p = 0; p < 5; p++) begin
        logic [31:0] v = rnd();
        logic [31:0] body = rnd();
        apply(pcs[p], {6'(op), body[25:0]}, v, v);
        apply(pcs[p], {6'(op), body[25:0]}, v, v ^ 32'h0000_0001);
        apply(pcs[p], {6'(op), body[25:0]}, v, ~v);
      end
    // R6 R1: function code sweep under opcode 0
    for (int fn = 0; fn < 64; fn++) begin
      apply(32'h0040_0100, {6'd0, 20'(rnd()), 6'(fn)}, rnd(), rnd());
      apply(32'hFFFF_FFFC, {6'd0, 20'(rnd()), 6'(fn)}, 32'h8000_0000, 32'd0);
    end
    // R2 R3 R8: offset extremes, both outcomes, wrap at both ends
    for (int p = 0; p < 5; p++)
      for (int o = 0; o < 6; o++) begin
        apply(pcs[p], {6'd4, 10'h155, offs[o]}, 32'd7, 32'd7);
        apply(pcs[p], {6'd4, 10'h155, offs[o]}, 32'd7, 32'd8);
        apply(pcs[p], {6'd5, 10'h0AA, offs[o]}, 32'd7, 32'd8);
        apply(pcs[p], {6'd5, 10'h0AA, offs[o]}, 32'd7, 32'd7);
      end
    // R4: word-index scaling, field 2500 near zero -> 10000
    apply(32'h0000_0000, {6'd2, 26'd2500}, 32'd0, 32'd0);
    apply(32'h0FFF_FFFC, {6'd2, 26'h3FF_FFFF}, 32'd0, 32'd0);
    // R5: call from top region
    apply(32'hF000_0000, {6'd3, 26'd2500}, 32'd1, 32'd2);
    apply(32'h0FFF_FFFC, {6'd3, 26'd0}, 32'd1, 32'd2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule